// File: doc/BRIEF.md
# I2C Host Clock-Stretch Timeout Detector

This block sits next to the SCL pad logic of an I2C host. It registers the host's request to pull SCL low and drives the pad from that register. It brings the open-drain SCL line back in through a two-flop synchronizer and counts the cycles during which the host has let SCL go but the synchronized line still reads low. A target that holds the clock low, for example while it prepares an acknowledge, keeps that count rising. The register on the pull path and the two synchronizer stages add three cycles of loop delay. Because of that delay, the count reaches 3 after each release even when no target holds the line.

When the count goes above a programmed limit and detection is enabled, a sticky interrupt status bit is set. Software clears the bit with a write-one-to-clear strobe. If the stretch is still in progress when software clears the bit, the condition still holds and the bit stays set. Each acknowledge that is stretched past the limit therefore gives one interrupt. A limit greater than 3 is needed to avoid false alarms caused by the loop delay.

Top module: `i2c_stretch_timeout`

## Requirements
- R1: While `rst` is high at a clock edge, `stretch_cnt` becomes 0, `stretch_irq` becomes 0 and `scl_pull_o` becomes 0 (released), and both synchronizer stages load 1.
- R2: `scl_pull_o` equals the value that `host_pull_req` had at the previous clock edge.
- R3: `scl_in` passes through two synchronizer flops. At each edge where `host_pull_req` is 0 and the synchronized SCL is 0, `stretch_cnt` increments by 1. After a release with no target holding the line, the peak count is exactly 3.
- R4: `stretch_cnt` becomes 0 at any edge where `host_pull_req` is 1 or the synchronized SCL is 1.
- R5: `stretch_cnt` saturates at 2^CNT_W-1 (65535 by default) and never wraps.
- R6: With `timeout_en`=1, `stretch_irq` becomes 1 at the edge after `stretch_cnt` exceeds `timeout_lim`. With a limit of 3, an unstretched release never sets it. With a limit of 2, an unstretched release does set it.
- R7: With `timeout_en`=0, `stretch_irq` is never set, however long the stretch lasts.
- R8: Once set, `stretch_irq` stays 1 until an `irq_clr` pulse arrives while the set condition is false. It is 0 one cycle after that pulse.
- R9: An `irq_clr` pulse that arrives while the count still exceeds the limit with detection enabled leaves `stretch_irq` at 1.
- R10: With a limit of 5, every acknowledge stretched past the limit gives exactly one rising edge of `stretch_irq` when software clears the bit after each one. A write of 3 data bytes gives 4 edges and a read gives 1 edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_pull_req | input | 1 | Host request to drive SCL low (1 = pull low) |
| scl_in | input | 1 | Raw SCL level sensed at the pad |
| timeout_lim | input | CNT_W | Stretch limit in cycles; the interrupt fires when the count exceeds it |
| timeout_en | input | 1 | Enables the stretch-timeout interrupt |
| irq_clr | input | 1 | Write-one-to-clear strobe for the status bit |
| scl_pull_o | output | 1 | Registered pad drive (1 = pull SCL low) |
| stretch_irq | output | 1 | Sticky stretch-timeout status |
| stretch_cnt | output | CNT_W | Current stretch count |

## Verification
The bench aims at the three-cycle loop delay. It checks that an unstretched release peaks at exactly 3, so a synchronizer that is one flop short or too long shows up in the count. It also checks that a limit of 2 gives a false alarm while a limit of 3 does not, which catches a comparator using >= instead of >. The bench clears the status both in the middle of a stretch and after it ends. A design where the clear wins over the set would drop the re-assertion, and a design that is not sticky would lose the interrupt after the stretch. A stretch of about 65,540 cycles against the maximum limit exposes a counter that wraps. Stretch sequences shaped like a write and a read check that each stretched acknowledge gives exactly one interrupt.

// File: rtl/stretch_pkg.sv
package stretch_pkg;

    localparam int DEF_CNT_W       = 16;
    localparam int DEF_SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        CNT_CLEAR = 2'd0,
        CNT_HOLD  = 2'd1,
        CNT_STEP  = 2'd2
    } cnt_action_e;

    // Decide what the stretch counter does this cycle.
    function automatic cnt_action_e pick_action(input logic host_low,
                                                input logic line_high,
                                                input logic at_max);
        if (host_low || line_high) return CNT_CLEAR;
        if (at_max)                return CNT_HOLD;
        return CNT_STEP;
    endfunction

    typedef struct packed {
        logic set_cond;
        logic clr_req;
    } irq_ctl_t;

endpackage

// File: rtl/scl_sync_in.sv
module scl_sync_in #(
    parameter int STAGES = stretch_pkg::DEF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_in,
    output logic synced
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b1;
                    else     chain[0] <= raw_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b1;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign synced = chain[STAGES-1];
endmodule

// File: rtl/stretch_counter.sv
module stretch_counter
    import stretch_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_low,
    input  logic             line_high,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    cnt_action_e act;

    always_comb act = pick_action(host_low, line_high, cnt == CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else begin
            unique case (act)
                CNT_CLEAR: cnt <= '0;
                CNT_STEP:  cnt <= cnt + CNT_ONE;
                default:   cnt <= cnt;
            endcase
        end
    end

    // R4
    clear_on_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (host_low || line_high) |=> cnt == '0);
    // R3
    step_chk: assert property (@(posedge clk) disable iff (rst)
        (!host_low && !line_high && cnt != CNT_MAX) |=> cnt == $past(cnt) + CNT_ONE);
    // R5
    no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (!host_low && !line_high && cnt == CNT_MAX) |=> cnt == CNT_MAX);
endmodule

// File: rtl/stretch_status.sv
module stretch_status
    import stretch_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] limit,
    input  logic             enable,
    input  logic             clr,
    output logic             irq
);
    irq_ctl_t ctl;

    always_comb begin
        ctl.set_cond = enable && (cnt > limit);
        ctl.clr_req  = clr;
    end

    always_ff @(posedge clk) begin
        if (rst)               irq <= 1'b0;
        else if (ctl.set_cond) irq <= 1'b1;
        else if (ctl.clr_req)  irq <= 1'b0;
    end

    // R7
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!enable && !irq) |=> !irq);
    // R8
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !clr) |=> irq);
    // R9
    reassert_chk: assert property (@(posedge clk) disable iff (rst)
        (enable && cnt > limit && clr) |=> irq);
    // R8
    clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && !(enable && cnt > limit)) |=> !irq);
endmodule

// File: rtl/i2c_stretch_timeout.sv
module i2c_stretch_timeout
    import stretch_pkg::*;
#(
    parameter int CNT_W       = DEF_CNT_W,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_pull_req,
    input  logic             scl_in,
    input  logic [CNT_W-1:0] timeout_lim,
    input  logic             timeout_en,
    input  logic             irq_clr,
    output logic             scl_pull_o,
    output logic             stretch_irq,
    output logic [CNT_W-1:0] stretch_cnt
);
    logic scl_synced;

    always_ff @(posedge clk) begin
        if (rst) scl_pull_o <= 1'b0;
        else     scl_pull_o <= host_pull_req;
    end

    scl_sync_in #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw_in (scl_in),
        .synced (scl_synced)
    );

    stretch_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .host_low  (host_pull_req),
        .line_high (scl_synced),
        .cnt       (stretch_cnt)
    );

    stretch_status #(.CNT_W(CNT_W)) u_stat (
        .clk    (clk),
        .rst    (rst),
        .cnt    (stretch_cnt),
        .limit  (timeout_lim),
        .enable (timeout_en),
        .clr    (irq_clr),
        .irq    (stretch_irq)
    );

    // R2
    pad_follows_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> scl_pull_o == $past(host_pull_req));
endmodule

// File: tb/i2c_stretch_timeout_bench.sv
module i2c_stretch_timeout_bench;
    localparam int W = 16;
    localparam int MAXV = (1 << W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_pull_req = 1'b0;
    logic hold = 1'b0;
    logic [W-1:0] timeout_lim = 16'd5;
    logic timeout_en = 1'b1;
    logic irq_clr = 1'b0;
    logic scl_pull_o, stretch_irq;
    logic [W-1:0] stretch_cnt;
    logic scl_in;

    assign scl_in = !(scl_pull_o || hold);

    i2c_stretch_timeout u_i2c_stretch_timeout (
        .clk(clk), .rst(rst), .host_pull_req(host_pull_req), .scl_in(scl_in),
        .timeout_lim(timeout_lim), .timeout_en(timeout_en), .irq_clr(irq_clr),
        .scl_pull_o(scl_pull_o), .stretch_irq(stretch_irq), .stretch_cnt(stretch_cnt)
    );

    always #5 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Behavioural reference model
    bit m_q[$] = '{1'b1, 1'b1};
    int m_cnt = 0;
    bit m_irq = 1'b0;
    bit m_pull = 1'b0;

    always @(posedge clk) begin
        bit synced, cond, raw;
        synced = m_q[0];
        raw = !(m_pull || hold);
        cond = timeout_en && (m_cnt > int'(timeout_lim));
        if (rst) begin
            m_q = '{1'b1, 1'b1};
            m_cnt = 0; m_irq = 1'b0; m_pull = 1'b0;
        end else begin
            void'(m_q.pop_front());
            m_q.push_back(raw);
            if (host_pull_req || synced) m_cnt = 0;
            else if (m_cnt < MAXV) m_cnt = m_cnt + 1;
            if (cond) m_irq = 1'b1;
            else if (irq_clr) m_irq = 1'b0;
            m_pull = host_pull_req;
        end
    end

    int peak = 0;
    int rises = 0;
    bit prev_irq = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            check(int'(stretch_cnt) == m_cnt, "R3/R4/R5 cnt", int'(stretch_cnt), m_cnt);
            check(stretch_irq == m_irq, "R6/R8/R9 irq", int'(stretch_irq), int'(m_irq));
            check(scl_pull_o == m_pull, "R2 pad", int'(scl_pull_o), int'(m_pull));
            if (int'(stretch_cnt) > peak) peak = int'(stretch_cnt);
            if (stretch_irq && !prev_irq) rises++;
        end
        prev_irq = stretch_irq;
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clr_pulse();
        @(negedge clk) irq_clr = 1'b1;
        @(negedge clk) irq_clr = 1'b0;
    endtask

    // One SCL high phase: host releases, target holds for 'st' cycles.
    task automatic high_phase(input int st);
        @(negedge clk);
        host_pull_req = 1'b0;
        hold = (st > 0);
        if (st > 0) begin
            cyc(st);
            hold = 1'b0;
        end
        cyc(6);
        host_pull_req = 1'b1;
        cyc(6);
    endtask

    task automatic ack_seq(input int n);
        for (int i = 0; i < n; i++) begin
            high_phase(12);
            clr_pulse();
        end
    endtask

    initial begin
        int cycles = 0;
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 200000) begin
                n_cmp++; n_bad++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 200000);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        end
    end

    initial begin
        cyc(3);
        @(negedge clk) rst = 1'b0;
        // R1: reset state
        check(stretch_cnt == 0, "R1 cnt", int'(stretch_cnt), 0);
        check(stretch_irq == 0, "R1 irq", int'(stretch_irq), 0);
        check(scl_pull_o == 0, "R1 pad", int'(scl_pull_o), 0);
        host_pull_req = 1'b1;
        cyc(4);
        // R2: pad driven from the request
        check(scl_pull_o == 1, "R2 pad low", int'(scl_pull_o), 1);

        // R3/R6: unstretched release with limit 3, peak 3, no irq
        timeout_lim = 16'd3;
        peak = 0;
        high_phase(0);
        check(peak == 3, "R3 peak", peak, 3);
        check(stretch_irq == 0, "R6 limit3 quiet", int'(stretch_irq), 0);
        // R4: count back to zero
        check(stretch_cnt == 0, "R4 cleared", int'(stretch_cnt), 0);

        // R6: limit 2 gives a false alarm
        timeout_lim = 16'd2;
        high_phase(0);
        check(stretch_irq == 1, "R6 limit2 fires", int'(stretch_irq), 1);
        // R8: sticky after condition ends
        cyc(5);
        check(stretch_irq == 1, "R8 sticky", int'(stretch_irq), 1);
        clr_pulse();
        check(stretch_irq == 0, "R8 cleared", int'(stretch_irq), 0);

        // R7: disabled, long stretch
        timeout_lim = 16'd5;
        timeout_en = 1'b0;
        high_phase(40);
        check(stretch_irq == 0, "R7 disabled", int'(stretch_irq), 0);
        timeout_en = 1'b1;

        // R9: clear during stretch
        @(negedge clk);
        host_pull_req = 1'b0;
        hold = 1'b1;
        cyc(15);
        check(stretch_irq == 1, "R9 set", int'(stretch_irq), 1);
        clr_pulse();
        check(stretch_irq == 1, "R9 reasserted", int'(stretch_irq), 1);
        hold = 1'b0;
        cyc(6);
        clr_pulse();
        check(stretch_irq == 0, "R9 later clear", int'(stretch_irq), 0);
        host_pull_req = 1'b1;
        cyc(4);

        // R10: write of 3 bytes, then a read
        rises = 0;
        ack_seq(4);
        check(rises == 4, "R10 write events", rises, 4);
        rises = 0;
        ack_seq(1);
        check(rises == 1, "R10 read events", rises, 1);

        // R5: saturation with maximum limit
        timeout_lim = 16'hFFFF;
        @(negedge clk);
        host_pull_req = 1'b0;
        hold = 1'b1;
        cyc(65545);
        check(stretch_cnt == 16'hFFFF, "R5 saturate", int'(stretch_cnt), MAXV);
        check(stretch_irq == 0, "R5 no irq at max", int'(stretch_irq), 0);
        hold = 1'b0;
        cyc(5);
        check(stretch_cnt == 0, "R4 after long", int'(stretch_cnt), 0);
        host_pull_req = 1'b1;
        cyc(3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule